// File: doc/BRIEF.md
# Multi-Mode Sample FIFO Controller

This block buffers fixed-width sensor samples. A small control register holds two fields: a 3-bit fill mode and a 4-bit acceptance rate. The mode decides what happens to incoming samples. They can be discarded, kept until the buffer fills, or kept with the newest entry replacing the oldest. Two modes depend on an external trigger and change their fill policy when the trigger falls. The rate field thins the producer's stream, so only a fraction of the valid samples reaches the buffer. A consumer drains the buffer through a pop port. The head word is always visible on the read data output.

The producer reports its own rate code on a separate input. When that code is above the selected rate code, only one sample in every 2^(producer code − selected code) is kept. When the producer is at or below the selected rate, every sample is kept.

Top module: `sample_fifo_ctrl`

## Requirements
- R1: After reset, the mode and rate fields are both zero. Level is 0, empty_o is 1 and full_o is 0.
- R2: Mode 000 and the reserved codes 010, 101 and 111 act as bypass. No valid sample raises the level.
- R3: Rate code 0000 disables the buffer under any mode. The level stays 0.
- R4: Mode 001 keeps samples until the level reaches DEPTH, then drops new ones. Pops return the first DEPTH samples in arrival order.
- R5: Mode 110 keeps accepting when full, discarding the oldest entry. Pops return the most recent DEPTH samples in order.
- R6: Mode 011 overwrites the oldest entry while the trigger is high. After the trigger falls (sampled on the clock), it stops collecting when full.
- R7: Mode 100 stores nothing while the trigger is high. After the trigger falls, it fills with overwrite of the oldest entry.
- R8: Let k = max(src_rate_i − rate field, 0). One of every 2^k valid samples is stored, starting with the first valid sample after the buffer is enabled.
- R9: A write that selects a bypass condition (R2 or R3) clears the level to 0 by the second clock edge after the write.
- R10: A pop while empty has no effect. full_o means level = DEPTH, empty_o means level = 0, and the level never exceeds DEPTH.
- R11: A push and a pop in the same cycle while full keep the level at DEPTH and lose no sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_mode_i | input | 3 | Fill mode to write |
| cfg_rate_i | input | 4 | Rate code to write (0 = disabled) |
| src_rate_i | input | 4 | Rate code of the producer |
| trig_i | input | 1 | External trigger |
| in_valid_i | input | 1 | Sample valid |
| in_data_i | input | DATA_W | Sample word |
| pop_i | input | 1 | Remove the head entry |
| rd_data_o | output | DATA_W | Head entry |
| full_o | output | 1 | Level equals DEPTH |
| empty_o | output | 1 | Level is zero |
| level_o | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
A wrong decimation count appears on level_o as soon as a burst of samples ends. For each rate pair, the bench compares that level and the indices of the first two stored samples against 2^k arithmetic. If the pointers slip in overwrite or stop mode, the order or identity of the popped words is wrong from the very first pop after a fill. A missed trigger switch or a missed flush shows on level_o within two cycles of the event that should have caused it.

// File: rtl/sample_fifo_pkg.sv
package sample_fifo_pkg;
  typedef enum logic [1:0] {
    POL_OFF  = 2'd0,
    POL_STOP = 2'd1,
    POL_WRAP = 2'd2
  } pol_t;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MD_STOP      = 3'b001;
  localparam logic [MODE_W-1:0] MD_WRAP_STOP = 3'b011;
  localparam logic [MODE_W-1:0] MD_OFF_WRAP  = 3'b100;
  localparam logic [MODE_W-1:0] MD_WRAP      = 3'b110;
endpackage

// File: rtl/sfc_policy.sv
module sfc_policy
  import sample_fifo_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              trig_i,
  output pol_t              pol_o
);
  logic trig_q, swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      swap_q <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (cfg_we_i)               swap_q <= 1'b0;
      else if (trig_q && !trig_i) swap_q <= 1'b1;
    end
  end

  always_comb begin
    pol_o = POL_OFF;
    if (rate_i != '0) begin
      unique case (mode_i)
        MD_STOP:      pol_o = POL_STOP;
        MD_WRAP:      pol_o = POL_WRAP;
        MD_WRAP_STOP: pol_o = swap_q ? POL_STOP : POL_WRAP;
        MD_OFF_WRAP:  pol_o = swap_q ? POL_WRAP : POL_OFF;
        default:      pol_o = POL_OFF;  // bypass and reserved codes
      endcase
    end
  end
endmodule

// File: rtl/sfc_decim.sv
module sfc_decim #(
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              take_o
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [RATE_W-1:0] k;
  logic [CNT_W-1:0]  cnt_q, mask;

  assign k      = (src_rate_i > rate_i) ? src_rate_i - rate_i : '0;
  assign mask   = ~({CNT_W{1'b1}} << k);
  assign take_o = valid_i && ((cnt_q & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (valid_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfc_store.sv
module sfc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic                       wrap_i,
  input  logic                       pop_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [DATA_W-1:0]          data_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  cnt_q;
  logic pop_ok, wr_ok, drop_old;

  assign full_o   = (cnt_q == LVL_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign level_o  = cnt_q;
  assign data_o   = mem[rd_q];
  assign pop_ok   = pop_i && !empty_o && !flush_i;
  assign wr_ok    = push_i && !flush_i && (!full_o || pop_ok || wrap_i);
  assign drop_old = wr_ok && full_o && !pop_ok;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok)              wr_q <= wr_q + 1'b1;
      if (pop_ok || drop_old) rd_q <= rd_q + 1'b1;
      if (wr_ok && !pop_ok && !full_o) cnt_q <= cnt_q + 1'b1;
      else if (!wr_ok && pop_ok)       cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sample_fifo_ctrl.sv
module sample_fifo_ctrl
  import sample_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int RATE_W = 4,
  localparam int LVL_W = $clog2(DEPTH+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic [RATE_W-1:0] cfg_rate_i,
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic              trig_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [MODE_W-1:0] mode_q;
  logic [RATE_W-1:0] rate_q;
  pol_t pol;
  logic flush, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '0;
    end else if (cfg_we_i) begin
      mode_q <= cfg_mode_i;
      rate_q <= cfg_rate_i;
    end
  end

  sfc_policy #(.RATE_W(RATE_W)) u_policy (
    .clk_i, .rst_ni, .cfg_we_i,
    .mode_i(mode_q), .rate_i(rate_q), .trig_i, .pol_o(pol)
  );

  assign flush = (pol == POL_OFF);

  sfc_decim #(.RATE_W(RATE_W)) u_decim (
    .clk_i, .rst_ni, .clr_i(flush), .valid_i(in_valid_i),
    .src_rate_i, .rate_i(rate_q), .take_o(take)
  );

  sfc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .flush_i(flush), .push_i(take),
    .wrap_i(pol == POL_WRAP), .pop_i, .data_i(in_data_i),
    .data_o(rd_data_o), .level_o, .full_o, .empty_o
  );
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker
  import sample_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pop_i,
  input logic [LVL_W-1:0] level_o,
  input logic             full_o,
  input pol_t             pol_i
);
  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_i == POL_OFF |=> level_o == '0);

  a_r2_off_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_i == POL_OFF |=> !(level_o > $past(level_o)));

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  a_r10_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1 ||
              level_o + 1'b1 == $past(level_o) || level_o == '0));

  a_r4_stop_holds_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pol_i == POL_STOP && !pop_i) |=> level_o == LVL_W'(DEPTH));

  a_r5_wrap_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pol_i == POL_WRAP && !pop_i) |=> full_o);
endmodule

bind sample_fifo_ctrl sfc_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pop_i(pop_i),
  .level_o(level_o), .full_o(full_o), .pol_i(pol)
);

// File: tb/sample_fifo_ctrl_test.sv
module sample_fifo_ctrl_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, trig = 0, in_valid = 0, pop = 0;
  logic [2:0] cfg_mode = 0;
  logic [3:0] cfg_rate = 0, src_rate = 0;
  logic [DATA_W-1:0] in_data = 0, rd_data;
  logic full, empty;
  logic [LVL_W-1:0] level;
  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  sample_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_rate_i(cfg_rate), .src_rate_i(src_rate), .trig_i(trig),
    .in_valid_i(in_valid), .in_data_i(in_data), .pop_i(pop),
    .rd_data_o(rd_data), .full_o(full), .empty_o(empty), .level_o(level)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_level(input string req, input int exp);
    check(int'(level) == exp, req, int'(level), exp);
  endtask

  task automatic write_cfg(input int mode, input int rate);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 3'(mode); cfg_rate = 4'(rate);
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = DATA_W'(base + i);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pop_expect(input string req, input int exp);
    @(negedge clk);
    check(int'(rd_data) == exp, req, int'(rd_data), exp);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int md[4] = '{0, 2, 5, 7};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk_level("R1 level", 0);
    check(empty == 1'b1, "R1 empty", int'(empty), 1);
    check(full == 1'b0, "R1 full", int'(full), 0);

    // R2 bypass and reserved codes
    foreach (md[j]) begin
      write_cfg(md[j], 4);
      push_n(10, 10);
      chk_level("R2 bypass/reserved", 0);
    end

    // R3 rate 0 disables
    write_cfg(1, 0);
    push_n(5, 20);
    chk_level("R3 rate zero", 0);

    // R4 stop when full
    write_cfg(1, 4);
    push_n(12, 100);
    chk_level("R4 level", DEPTH);
    check(full == 1'b1, "R4 full", int'(full), 1);
    for (int i = 0; i < DEPTH; i++) pop_expect("R4 order", 100 + i);
    check(empty == 1'b1, "R4 empty after drain", int'(empty), 1);
    // R10 pop on empty
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    chk_level("R10 pop empty", 0);
    check(empty == 1'b1, "R10 empty flag", int'(empty), 1);

    // R5 overwrite oldest
    write_cfg(0, 4);
    write_cfg(6, 4);
    push_n(12, 200);
    chk_level("R5 level", DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_expect("R5 order", 204 + i);

    // R11 push and pop together while full
    push_n(8, 300);
    check(int'(rd_data) == 300, "R11 head", int'(rd_data), 300);
    in_valid = 1; in_data = 308; pop = 1;
    @(negedge clk);
    in_valid = 0; pop = 0;
    chk_level("R11 level", DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_expect("R11 order", 301 + i);

    // R6 overwrite while trigger high, then stop
    write_cfg(0, 4);
    trig = 1;
    @(negedge clk);
    write_cfg(3, 4);
    push_n(12, 400);
    chk_level("R6 wrap phase", DEPTH);
    trig = 0;
    @(negedge clk); @(negedge clk);
    push_n(3, 500);
    chk_level("R6 stop phase level", DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_expect("R6 order", 404 + i);

    // R7 bypass while trigger high, then overwrite
    write_cfg(0, 4);
    trig = 1;
    @(negedge clk);
    write_cfg(4, 4);
    push_n(5, 550);
    chk_level("R7 bypass phase", 0);
    trig = 0;
    @(negedge clk); @(negedge clk);
    push_n(10, 600);
    chk_level("R7 wrap phase", DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_expect("R7 order", 602 + i);

    // R8 decimation sweep
    for (int s = 0; s < 5; s++) begin
      for (int r = 1; r < 5; r++) begin
        int k, expn;
        k = (s > r) ? s - r : 0;
        expn = (16 >> k) > DEPTH ? DEPTH : (16 >> k);
        write_cfg(0, 4);
        src_rate = 4'(s);
        write_cfg(1, r);
        push_n(16, 0);
        chk_level("R8 kept count", expn);
        pop_expect("R8 first kept", 0);
        if (expn >= 2) pop_expect("R8 second kept", 1 << k);
      end
    end
    src_rate = 0;

    // R9 flush on bypass write
    write_cfg(0, 4);
    write_cfg(1, 4);
    push_n(5, 700);
    chk_level("R9 before flush", 5);
    @(negedge clk);
    cfg_we = 1; cfg_mode = 0; cfg_rate = 4;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
    chk_level("R9 flushed", 0);
    write_cfg(1, 4);
    chk_level("R9 stays empty", 0);

    summary();
  end
endmodule